// File: doc/BRIEF.md
# DMA Interrupt Control and Status Register

This block holds the interrupt control and status word shared by a set of DMA channels. Software writes it to set a force bit, one interrupt enable per channel, a master enable and a few spare scratch bits. The same write can clear per-channel completion flags by writing 1 to them. A channel's transfer logic reports a finished transfer with a one-cycle pulse on its bit of `ch_done`. The flag for that channel is recorded only when the channel's enable is set.

A master condition is computed from the stored state: the force bit, or the master enable together with at least one flag whose enable is also set. The condition is read back as the top bit of the word. It is never stored as written data. The system interrupt controller receives a one-clock request pulse only when this condition changes from false to true. The request is armed again only after the condition has gone false, which happens when flags are acknowledged, enables are removed or the force bit is cleared.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0 and `irq_pulse` is 0.
- R2: A write (`wr_en`=1) loads bits [5:0] (spare), bit 15 (force), bits [22:16] (channel enables, bit 16+n for channel n) and bit 23 (master enable) from `wr_data`. The new values are visible on `rd_data` from the next cycle. Bits [14:6] always read 0.
- R3: A write with `wr_data` bit 24+n set clears flag n (read at bit 24+n). A 0 in that bit leaves the flag unchanged. Flags change only through acknowledges and completions.
- R4: A pulse on `ch_done[n]` sets flag n only if enable bit 16+n, as held before that clock edge, is set. Otherwise the completion is dropped.
- R5: If a completion and an acknowledge of the same flag arrive in the same cycle, the flag ends up set.
- R6: `rd_data` bit 31 reads force OR (master enable AND any flag n together with enable n), evaluated on the current register contents. Writing bit 31 has no effect.
- R7: `irq_pulse` is high for exactly the one cycle in which bit 31 first reads 1 after having read 0.
- R8: While bit 31 stays 1, further completions, writes or forcing raise no new pulse. After bit 31 has read 0, the next rise produces a new pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| ch_done | input | NUM_CH | Per-channel transfer-complete pulses |
| rd_data | output | 32 | Current register value, with the derived master bit in bit 31 |
| irq_pulse | output | 1 | One-clock interrupt request to the system interrupt controller |

## Verification
The main stimulus runs through all 128 channel-enable masks. Each mask is followed first by completions on every channel and then by an irregular completion pattern. This shows whether gating uses the matching enable bit and not a neighbouring one. Same-cycle acknowledge and completion patterns test which of the two takes priority. Sequences that hold the master condition high test edge detection against level detection: further completions, partial acknowledges and forcing while it is high must raise no pulse. Sequences that drop the condition by clearing enables without acknowledging flags, or by clearing the master enable, then check that the request re-arms. Writes of all ones, of zero and of alternating patterns test the writable field layout, the zero-read bits and the ignored master bit.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
    localparam int REG_W     = 32;
    localparam int SPARE_W   = 6;
    localparam int FORCE_POS = 15;
    localparam int ENA_LSB   = 16;
    localparam int MEN_POS   = 23;
    localparam int FLG_LSB   = 24;
    localparam int MFLAG_POS = 31;
    localparam int MAX_CH    = 7;
endpackage

// File: rtl/dmairq_flag_bank.sv
module dmairq_flag_bank #(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic [NUM_CH-1:0] ch_en_q,
    input  logic [NUM_CH-1:0] ack,
    output logic [NUM_CH-1:0] flag_d,
    output logic [NUM_CH-1:0] flag_q
);
    // A completion that passes its gate takes priority over an acknowledge.
    always_comb begin
        for (int n = 0; n < NUM_CH; n++) begin
            if (ch_done[n] && ch_en_q[n]) begin
                flag_d[n] = 1'b1;
            end else if (ack[n]) begin
                flag_d[n] = 1'b0;
            end else begin
                flag_d[n] = flag_q[n];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end
endmodule

// File: rtl/dmairq_master_eval.sv
module dmairq_master_eval #(
    parameter int NUM_CH = 7
) (
    input  logic              force_irq,
    input  logic              master_en,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ch_flag,
    output logic              cond
);
    logic any_armed;

    always_comb begin
        any_armed = |(ch_en & ch_flag);
        cond      = force_irq | (master_en & any_armed);
    end
endmodule

// File: rtl/dmairq_edge_pulse.sv
module dmairq_edge_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_d,
    output logic level_q,
    output logic pulse_q
);
    typedef struct packed {
        logic level;
        logic pulse;
    } edge_t;

    edge_t st_d, st_q;

    // The stored level doubles as the edge latch: it re-arms once the condition drops.
    always_comb begin
        st_d.level = cond_d;
        st_d.pulse = cond_d & ~st_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_q = st_q.level;
    assign pulse_q = st_q.pulse;
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [NUM_CH-1:0] ch_done,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq_pulse
);
    typedef struct packed {
        logic [SPARE_W-1:0] spare;
        logic               force_irq;
        logic [NUM_CH-1:0]  ch_en;
        logic               master_en;
    } ctrl_t;

    ctrl_t             ctrl_d, ctrl_q;
    logic [NUM_CH-1:0] ack;
    logic [NUM_CH-1:0] flag_d, flag_q;
    logic              cond_d, cond_q;
    logic              unused_wr;

    assign unused_wr = ^{wr_data[MFLAG_POS], wr_data[FORCE_POS-1:SPARE_W]};

    always_comb begin
        ctrl_d = ctrl_q;
        ack    = '0;
        if (wr_en) begin
            ctrl_d.spare     = wr_data[SPARE_W-1:0];
            ctrl_d.force_irq = wr_data[FORCE_POS];
            ctrl_d.ch_en     = wr_data[ENA_LSB +: NUM_CH];
            ctrl_d.master_en = wr_data[MEN_POS];
            ack              = wr_data[FLG_LSB +: NUM_CH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    dmairq_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ch_done (ch_done),
        .ch_en_q (ctrl_q.ch_en),
        .ack     (ack),
        .flag_d  (flag_d),
        .flag_q  (flag_q)
    );

    // The condition is evaluated on next-state values so that the pulse lines up
    // with the first cycle in which the master bit reads 1.
    dmairq_master_eval #(.NUM_CH(NUM_CH)) u_eval (
        .force_irq (ctrl_d.force_irq),
        .master_en (ctrl_d.master_en),
        .ch_en     (ctrl_d.ch_en),
        .ch_flag   (flag_d),
        .cond      (cond_d)
    );

    dmairq_edge_pulse u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond_d  (cond_d),
        .level_q (cond_q),
        .pulse_q (irq_pulse)
    );

    always_comb begin
        rd_data                      = '0;
        rd_data[SPARE_W-1:0]         = ctrl_q.spare;
        rd_data[FORCE_POS]           = ctrl_q.force_irq;
        rd_data[ENA_LSB +: NUM_CH]   = ctrl_q.ch_en;
        rd_data[MEN_POS]             = ctrl_q.master_en;
        rd_data[FLG_LSB +: NUM_CH]   = flag_q;
        rd_data[MFLAG_POS]           = cond_q;
    end
endmodule

// File: rtl/dmairq_checker.sv
module dmairq_checker
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic [NUM_CH-1:0] ch_done,
    input logic [REG_W-1:0]  rd_data,
    input logic              irq_pulse
);
    localparam logic [REG_W-1:0] WR_MASK =
        ((REG_W'(1) << SPARE_W) - REG_W'(1)) |
        (REG_W'(1) << FORCE_POS) |
        (((REG_W'(1) << NUM_CH) - REG_W'(1)) << ENA_LSB) |
        (REG_W'(1) << MEN_POS);

    assert_write_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_data & WR_MASK) == ($past(wr_data) & WR_MASK)));

    assert_idle_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[FORCE_POS-1:SPARE_W] == '0);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[FLG_LSB+n] && !ch_done[n]) |=> !rd_data[FLG_LSB+n]);

        assert_flag_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[FLG_LSB+n] && !(wr_en && wr_data[FLG_LSB+n])) |=> rd_data[FLG_LSB+n]);

        assert_gated_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_done[n] && !rd_data[ENA_LSB+n] && !rd_data[FLG_LSB+n]) |=> !rd_data[FLG_LSB+n]);

        assert_done_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_done[n] && rd_data[ENA_LSB+n]) |=> rd_data[FLG_LSB+n]);
    end

    assert_force_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[FORCE_POS] |-> rd_data[MFLAG_POS]);

    assert_no_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[FORCE_POS] && !rd_data[MEN_POS]) |-> !rd_data[MFLAG_POS]);

    assert_pulse_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[MFLAG_POS]) |-> irq_pulse);

    assert_pulse_only_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $rose(rd_data[MFLAG_POS]));
endmodule

bind dma_irq_ctrl dmairq_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ch_done   (ch_done),
    .rd_data   (rd_data),
    .irq_pulse (irq_pulse)
);

// File: tb/dma_irq_ctrl_tb.sv
`timescale 1ns/1ps
module dma_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [6:0]  ch_done = '0;
    logic [31:0] rd_data;
    logic        irq_pulse;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // bench model of the register
    logic [5:0] m_spare = '0;
    logic       m_force = 1'b0;
    logic [6:0] m_en = '0;
    logic       m_men = 1'b0;
    logic [6:0] m_flag = '0;
    logic       m_cond = 1'b0;

    always #10 clk = ~clk;

    dma_irq_ctrl #(.NUM_CH(7)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ch_done   (ch_done),
        .rd_data   (rd_data),
        .irq_pulse (irq_pulse)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [31:0] d, input logic [6:0] dn, input string tag);
        logic [6:0]  nflag;
        logic        ncond;
        logic        exp_irq;
        logic [31:0] exp_rd;
        @(negedge clk);
        wr_en = w;
        wr_data = d;
        ch_done = dn;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        ch_done = '0;
        nflag = (dn & m_en) | (m_flag & ~(w ? d[30:24] : 7'd0));
        if (w) begin
            m_spare = d[5:0];
            m_force = d[15];
            m_en    = d[22:16];
            m_men   = d[23];
        end
        m_flag  = nflag;
        ncond   = m_force | (m_men & (|(m_flag & m_en)));
        exp_irq = ncond & ~m_cond;
        m_cond  = ncond;
        exp_rd  = {m_cond, m_flag, m_men, m_en, m_force, 9'd0, m_spare};
        check(tag, "rd_data", rd_data, exp_rd);
        check(tag, "irq_pulse", {31'd0, irq_pulse}, {31'd0, exp_irq});
    endtask

    function automatic logic [31:0] cfg(input logic frc, input logic men, input logic [6:0] en, input logic [6:0] ackm);
        return {1'b0, ackm, men, en, frc, 15'd0};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [6:0] lfsr;
        lfsr = 7'h5B;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "rd_data", rd_data, 32'd0);
        check("R1", "irq_pulse", {31'd0, irq_pulse}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "rd_data", rd_data, 32'd0);

        // R2: field layout, zero-read bits, bit 31 ignored
        step(1'b1, 32'hFFFF_FFFF, 7'd0, "R2");
        step(1'b1, 32'h0000_0000, 7'd0, "R2");
        step(1'b1, 32'h0055_7FEA, 7'd0, "R2");
        step(1'b1, 32'h00AA_0015, 7'd0, "R2");
        step(1'b1, 32'h8000_0000, 7'd0, "R6");

        // R4: every enable mask, full and irregular completion patterns
        for (int mask = 0; mask < 128; mask++) begin
            step(1'b1, cfg(1'b0, 1'b1, 7'(mask), 7'h7F), 7'd0, "R3");
            step(1'b0, 32'd0, 7'h7F, "R4");
            lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
            step(1'b1, cfg(1'b0, mask[0], 7'(mask), 7'h7F), lfsr, "R4");
            step(1'b0, 32'd0, ~lfsr, "R4");
        end

        // R5: same-cycle acknowledge and completion
        step(1'b1, cfg(1'b0, 1'b1, 7'h7F, 7'h7F), 7'd0, "R3");
        step(1'b0, 32'd0, 7'h7F, "R5");
        step(1'b1, cfg(1'b0, 1'b1, 7'h7F, 7'h7F), 7'h55, "R5");
        step(1'b1, cfg(1'b0, 1'b1, 7'h7F, 7'h00), 7'h00, "R3");
        step(1'b1, cfg(1'b0, 1'b1, 7'h7F, 7'h7F), 7'h00, "R3");

        // R6: force without master enable, retained flags with enable removed
        step(1'b1, cfg(1'b1, 1'b0, 7'h00, 7'h00), 7'd0, "R6");
        step(1'b1, cfg(1'b0, 1'b0, 7'h00, 7'h00), 7'd0, "R6");
        step(1'b1, cfg(1'b0, 1'b1, 7'h01, 7'h00), 7'd0, "R6");
        step(1'b0, 32'd0, 7'h01, "R7");
        step(1'b1, cfg(1'b0, 1'b1, 7'h00, 7'h00), 7'd0, "R6");
        step(1'b1, cfg(1'b0, 1'b1, 7'h01, 7'h00), 7'd0, "R8");
        step(1'b1, cfg(1'b0, 1'b0, 7'h01, 7'h00), 7'd0, "R8");
        step(1'b1, cfg(1'b0, 1'b1, 7'h01, 7'h00), 7'd0, "R8");

        // R8: no repeat while high, re-arm after drop
        step(1'b1, cfg(1'b0, 1'b1, 7'h07, 7'h00), 7'd0, "R8");
        step(1'b0, 32'd0, 7'h02, "R8");
        step(1'b1, cfg(1'b1, 1'b1, 7'h07, 7'h00), 7'd0, "R8");
        step(1'b1, cfg(1'b0, 1'b1, 7'h07, 7'h01), 7'd0, "R8");
        step(1'b1, cfg(1'b0, 1'b1, 7'h07, 7'h02), 7'd0, "R8");
        step(1'b0, 32'd0, 7'h04, "R7");
        step(1'b0, 32'd0, 7'h00, "R7");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule